// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address that one port of a dual-ported memory presents to its address register. A start address is loaded from outside. Each cycle with the increment control high, the counter then steps internally. A programmable mask register selects which address bits take part in the count. Bits outside the mask keep the value they were loaded with. When every counted bit is at one and a further increment arrives, the counted bits return to zero. That wrap sets a sticky interrupt flag.

The block remembers the last loaded start address, so a burst can be restarted from it with a retransmit request. For readback, the address output can show either the live counter value or the mask register. A companion output tells the surrounding logic that readback is in progress and the address lines are being driven.

An active-high master reset is asynchronous. It clears the counter, the saved start and the interrupt, and sets the mask to all ones so that counting covers the full address range.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high, and afterwards until another control acts, the counter is 0, the saved start is 0, the mask is all ones and `wrap_irq` is 0.
- R2: A cycle with `ld` high copies `addr_in` into both the counter and the saved start, and clears `wrap_irq`.
- R3: With the mask all ones, each cycle with `inc` high adds one to the counter modulo 2^AW, so the counter steps from all ones back to 0.
- R4: With any mask, an increment leaves every bit whose mask bit is 0 unchanged. The bits whose mask bit is 1, read in ascending bit order as one number, go up by one. When all of them are already 1, they all become 0.
- R5: `wrap_irq` is set by an increment that finds every counted bit at 1. It then stays set through later increments, retransmits and mask loads until a load or a reset clears it.
- R6: A cycle with `mask_ld` high copies `addr_in` into the mask and leaves the counter unchanged.
- R7: A cycle with `rtx` high puts the saved start address back into the counter.
- R8: When several controls are high in one cycle, only the highest of the order `ld`, `mask_ld`, `rtx`, `inc` acts, and the others have no effect that cycle.
- R9: `addr_out` shows the mask when `mask_rd` is high, and the counter otherwise, including when only `cnt_rd` is high. `rb_drive` is 1 exactly when `cnt_rd` or `mask_rd` is high.
- R10: With the mask all zeros, an increment leaves the counter unchanged and sets `wrap_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous master reset, active high |
| addr_in | input | AW | Start address or mask value |
| ld | input | 1 | Load counter and saved start from `addr_in` |
| inc | input | 1 | Advance the counter within the mask |
| rtx | input | 1 | Restart from the saved start address |
| mask_ld | input | 1 | Load the mask register from `addr_in` |
| cnt_rd | input | 1 | Request readback of the counter |
| mask_rd | input | 1 | Request readback of the mask |
| addr_out | output | AW | Counter value, or mask value during mask readback |
| rb_drive | output | 1 | High while a readback is requested |
| wrap_irq | output | 1 | Sticky wrap-around flag |

## Verification
A four-bit instance is swept over every one of the 16 masks crossed with every one of the 16 start addresses. Each pairing runs one more increment than a full cycle of the address space, so that every mask shape reaches its wrap. The all-ones mask separates plain modulo counting from masked counting. The all-zeros mask and the single-bit masks test the degenerate windows. Non-contiguous masks show whether carries skip the held bits correctly. Further cycles assert several controls at once to expose a wrong priority order, and one cycle applies reset in the middle of a run to show that the saved start returns to zero.

// File: rtl/bag_pkg.sv
`timescale 1ns/1ps
package bag_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_MASK = 3'd2,
    OP_RTX  = 3'd3,
    OP_INC  = 3'd4
  } bag_op_e;
endpackage

// File: rtl/bag_decode.sv
`timescale 1ns/1ps
// Resolves simultaneous controls into a single operation by fixed priority.
module bag_decode
  import bag_pkg::*;
(
  input  logic    ld,
  input  logic    mask_ld,
  input  logic    rtx,
  input  logic    inc,
  output bag_op_e op
);
  always_comb begin
    if (ld)           op = OP_LOAD;
    else if (mask_ld) op = OP_MASK;
    else if (rtx)     op = OP_RTX;
    else if (inc)     op = OP_INC;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/bag_step.sv
`timescale 1ns/1ps
// Next value of a counter whose counting bits are chosen by a mask.
// Held bits are forced to one before the add so a carry passes over them.
module bag_step #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cnt,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] nxt,
  output logic          wrap
);
  logic [AW-1:0] fill;
  logic [AW-1:0] sum;

  always_comb begin
    fill = cnt | ~mask;
    sum  = fill + {{(AW-1){1'b0}}, 1'b1};
    nxt  = (cnt & ~mask) | (sum & mask);
    wrap = &fill;
  end
endmodule

// File: rtl/bag_rbmux.sv
`timescale 1ns/1ps
// Readback selection onto the address output.
module bag_rbmux #(
  parameter int AW = 8
) (
  input  logic          cnt_rd,
  input  logic          mask_rd,
  input  logic [AW-1:0] cnt,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] addr,
  output logic          drive
);
  always_comb begin
    addr  = mask_rd ? mask : cnt;
    drive = cnt_rd | mask_rd;
  end
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          ld,
  input  logic          inc,
  input  logic          rtx,
  input  logic          mask_ld,
  input  logic          cnt_rd,
  input  logic          mask_rd,
  output logic [AW-1:0] addr_out,
  output logic          rb_drive,
  output logic          wrap_irq
);
  localparam logic [AW-1:0] MASK_RST = {AW{1'b1}};

  bag_op_e       op;
  logic [AW-1:0] cnt_q, mask_q, base_q;
  logic [AW-1:0] cnt_nxt;
  logic          wrap;
  logic          irq_q;

  bag_decode u_dec (
    .ld      (ld),
    .mask_ld (mask_ld),
    .rtx     (rtx),
    .inc     (inc),
    .op      (op)
  );

  bag_step #(.AW(AW)) u_step (
    .cnt  (cnt_q),
    .mask (mask_q),
    .nxt  (cnt_nxt),
    .wrap (wrap)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q  <= '0;
      base_q <= '0;
      mask_q <= MASK_RST;
      irq_q  <= 1'b0;
    end else begin
      case (op)
        OP_LOAD: begin
          cnt_q  <= addr_in;
          base_q <= addr_in;
          irq_q  <= 1'b0;
        end
        OP_MASK: mask_q <= addr_in;
        OP_RTX:  cnt_q  <= base_q;
        OP_INC: begin
          cnt_q <= cnt_nxt;
          if (wrap) irq_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  bag_rbmux #(.AW(AW)) u_rb (
    .cnt_rd  (cnt_rd),
    .mask_rd (mask_rd),
    .cnt     (cnt_q),
    .mask    (mask_q),
    .addr    (addr_out),
    .drive   (rb_drive)
  );

  assign wrap_irq = irq_q;
endmodule

// File: rtl/bag_checker.sv
`timescale 1ns/1ps
module bag_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_in,
  input logic          ld,
  input logic          inc,
  input logic          rtx,
  input logic          mask_ld,
  input logic [AW-1:0] cnt_q,
  input logic [AW-1:0] mask_q,
  input logic [AW-1:0] base_q,
  input logic          wrap_irq
);
  a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_q == $past(addr_in)) && !wrap_irq);

  a_r6_mask_load_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (!ld && mask_ld) |=> (cnt_q == $past(cnt_q)) && (mask_q == $past(addr_in)));

  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (wrap_irq && !ld) |=> wrap_irq);

  a_r4_held_bits_stay: assert property (@(posedge clk) disable iff (rst)
    (!ld && !mask_ld && !rtx && inc) |=> ((cnt_q ^ $past(cnt_q)) & ~$past(mask_q)) == '0);

  a_r7_retransmit: assert property (@(posedge clk) disable iff (rst)
    (!ld && !mask_ld && rtx) |=> cnt_q == $past(base_q));

  a_r8_no_change_idle: assert property (@(posedge clk) disable iff (rst)
    (!ld && !mask_ld && !rtx && !inc) |=> $stable(cnt_q) && $stable(mask_q) && $stable(wrap_irq));
endmodule

bind burst_addr_gen bag_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr_in  (addr_in),
  .ld       (ld),
  .inc      (inc),
  .rtx      (rtx),
  .mask_ld  (mask_ld),
  .cnt_q    (cnt_q),
  .mask_q   (mask_q),
  .base_q   (base_q),
  .wrap_irq (wrap_irq)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          ld = 0, inc = 0, rtx = 0, mask_ld = 0, cnt_rd = 0, mask_rd = 0;
  logic [AW-1:0] addr_out;
  logic          rb_drive, wrap_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ld(ld), .inc(inc), .rtx(rtx),
    .mask_ld(mask_ld), .cnt_rd(cnt_rd), .mask_rd(mask_rd),
    .addr_out(addr_out), .rb_drive(rb_drive), .wrap_irq(wrap_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock with the given controls; outputs are sampled 1 ns after the edge.
  task automatic cyc(input logic l, input logic i, input logic r, input logic m,
                     input logic [AW-1:0] a);
    @(negedge clk);
    ld = l; inc = i; rtx = r; mask_ld = m; addr_in = a;
    @(posedge clk);
    #1;
    ld = 0; inc = 0; rtx = 0; mask_ld = 0;
  endtask

  task automatic peek_mask(input string req, input int exp);
    mask_rd = 1; #0.5;
    check(req, int'(addr_out), exp);
    mask_rd = 0; #0.5;
  endtask

  // Gather the counted bits, add one, scatter them back.
  function automatic void model_inc(input logic [AW-1:0] c, input logic [AW-1:0] m,
                                    output logic [AW-1:0] nx, output logic wr);
    int v = 0;
    int n = 0;
    for (int b = 0; b < AW; b++)
      if (m[b]) begin v = v | (int'(c[b]) << n); n++; end
    wr = ((v + 1) == (1 << n));
    v = (v + 1) % (1 << n);
    nx = c;
    n = 0;
    for (int b = 0; b < AW; b++)
      if (m[b]) begin nx[b] = v[n]; n++; end
  endfunction

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] exp_c;
    logic          exp_i, w;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 cnt", int'(addr_out), 0);
    check("R1 irq", int'(wrap_irq), 0);
    check("R9 no drive", int'(rb_drive), 0);
    peek_mask("R1 mask", N - 1);
    @(negedge clk); rst = 0;

    // Sweep all masks and starts: R2, R3, R4, R5, R10, R7, R6
    for (int m = 0; m < N; m++) begin
      for (int s = 0; s < N; s++) begin
        cyc(0, 0, 0, 1, AW'(m));
        check("R6 mask", int'(uut.u_rb.mask), m);
        cyc(1, 0, 0, 0, AW'(s));
        check("R2 load", int'(addr_out), s);
        check("R2 irq clear", int'(wrap_irq), 0);
        exp_c = AW'(s);
        exp_i = 0;
        for (int k = 0; k <= N; k++) begin
          model_inc(exp_c, AW'(m), exp_c, w);
          if (w) exp_i = 1;
          cyc(0, 1, 0, 0, '0);
          if (m == N - 1)  check("R3 step", int'(addr_out), int'(exp_c));
          else if (m == 0) check("R10 hold", int'(addr_out), int'(exp_c));
          else             check("R4 step", int'(addr_out), int'(exp_c));
          check("R5 irq", int'(wrap_irq), int'(exp_i));
        end
        cyc(0, 0, 1, 0, '0);
        check("R7 restart", int'(addr_out), s);
        check("R5 irq after rtx", int'(wrap_irq), int'(exp_i));
        cyc(0, 0, 0, 1, AW'(m ^ 5));
        check("R6 cnt kept", int'(addr_out), s);
        check("R5 irq after mask", int'(wrap_irq), int'(exp_i));
      end
    end

    // R8 priority
    cyc(0, 0, 0, 1, 4'hF);
    cyc(1, 0, 0, 0, 4'h3);
    cyc(1, 1, 1, 1, 4'h9);
    check("R8 ld wins", int'(addr_out), 9);
    peek_mask("R8 mask untouched", 15);
    cyc(0, 1, 1, 1, 4'h6);
    check("R8 mask_ld over rtx/inc cnt", int'(addr_out), 9);
    peek_mask("R8 mask_ld wins", 6);
    cyc(0, 0, 0, 1, 4'hF);
    cyc(0, 1, 0, 0, '0);
    check("R3 inc", int'(addr_out), 10);
    cyc(0, 1, 1, 0, '0);
    check("R8 rtx over inc", int'(addr_out), 9);

    // R9 readback
    @(negedge clk); cnt_rd = 1; #0.5;
    check("R9 cnt rb", int'(addr_out), 9);
    check("R9 drive", int'(rb_drive), 1);
    mask_rd = 1; #0.5;
    check("R9 mask over cnt", int'(addr_out), 15);
    cnt_rd = 0; #0.5;
    check("R9 drive mask", int'(rb_drive), 1);
    mask_rd = 0; #0.5;
    check("R9 drive off", int'(rb_drive), 0);

    // R1 reset mid-run, saved start cleared
    cyc(0, 0, 0, 1, 4'h3);
    cyc(1, 0, 0, 0, 4'hB);
    @(negedge clk); rst = 1; #1;
    check("R1 async cnt", int'(addr_out), 0);
    @(negedge clk); rst = 0;
    peek_mask("R1 mask after reset", 15);
    cyc(0, 0, 1, 0, '0);
    check("R7 start after reset", int'(addr_out), 0);
    check("R1 irq", int'(wrap_irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule